// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the eight-bit line status word of a UART whose receive and transmit paths are buffered. It consumes events from the receiver, such as a finished character and its parity, framing and break flags. It also consumes events from the transmitter: a byte loaded by the host, a byte moved into the shift register, and the shift register busy level. From these it builds the status word for the host. Each received character is stored with its three error flags in an 11-bit entry. Those flags are shown only while that entry sits at the head of the receive store. A summary bit records whether any flagged entry is still waiting.

The host has three strobes: one to read received data (pop the head), one to read the status word, and one to write the status word, which has no effect. In FIFO mode (`fifo_mode`=1) the receive store holds `RX_DEPTH` characters and the transmit side holds `TX_DEPTH` bytes. In single-buffer mode both hold one. `fifo_mode` changes only while reset is asserted.

Receive occupancy is tracked by a state machine with three states:
- `OCC_EMPTY` goes to `OCC_PART` on a push. It goes straight to `OCC_FULL` when the capacity is one.
- `OCC_PART` goes to `OCC_FULL` when the count reaches capacity, and back to `OCC_EMPTY` when the last entry is popped.
- `OCC_FULL` goes to `OCC_PART` on a pop that is not matched by a push. It goes to `OCC_EMPTY` when the capacity is one.

Top module: `uart_lsr_tracker`

## Requirements
- R1: After reset the status word is 8'h60, `rx_head` is 0 and `lsi_irq` is 0.
- R2: Bit 0 (data ready) is 1 from the cycle after a character is stored until the cycle after the last stored character is popped by `host_rd_data`.
- R3: In FIFO mode up to `RX_DEPTH` characters are kept and leave through `rx_head` in arrival order. In single-buffer mode one is kept. `rx_head` is 0 when nothing is stored.
- R4: In FIFO mode, a character that completes while the store is full and no data read happens in that cycle is dropped and sets bit 1 (overrun) in the next cycle. The stored characters are unchanged.
- R5: In single-buffer mode, a character that completes while the buffer is full and unread replaces the stored character and sets bit 1.
- R6: Bits 2, 3 and 4 are the parity, framing and break flags of the head character. They are 0 when the store is empty, and flags of entries behind the head are not visible.
- R7: A status read clears bit 1 and the head's flags (bits 2 to 4) from the next cycle. An overrun in the same cycle as the read leaves bit 1 at 1.
- R8: Bit 7 is 0 in single-buffer mode. In FIFO mode it is 1 from the cycle after a flagged character is stored. It stays 1 even if that character is popped, and a status read clears it only if no flagged entry remains after the read's own clearing.
- R9: Bit 5 is 1 when the transmit holding store is empty. `tx_load` adds a byte if there is room after any same-cycle `tx_move`. `tx_move` removes one byte if any is present.
- R10: Bit 6 is 1 only when bit 5 is 1 and `tx_shift_busy` is 0.
- R11: `lsi_irq` is 1 exactly when `lsi_en` is 1 and any of bits 1 to 4 is 1.
- R12: `host_wr_lsr` changes nothing in the status word.
- R13: With the store full, a character arriving in the same cycle as a data read is stored and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 selects buffered mode, 0 single-buffer mode |
| rx_done | input | 1 | A received character is complete |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error of the character |
| rx_ferr | input | 1 | Framing error of the character |
| rx_brk | input | 1 | Break seen for the character |
| host_rd_data | input | 1 | Host reads (pops) the head character |
| host_rd_lsr | input | 1 | Host reads the status word |
| host_wr_lsr | input | 1 | Host writes the status word (ignored) |
| tx_load | input | 1 | Host writes a byte to transmit |
| tx_move | input | 1 | A byte moves into the transmit shift register |
| tx_shift_busy | input | 1 | Transmit shift register holds data |
| lsi_en | input | 1 | Line status interrupt enable |
| lsr | output | 8 | Line status word |
| rx_head | output | 8 | Head character of the receive store |
| lsi_irq | output | 1 | Line status interrupt request |

## Verification
The case that needs most care is a status read in the same cycle as a new character. When the store is full and no data read is made, the read's clearing of bit 1 collides with a fresh overrun, and the overrun must win. The bench fills the store, then asserts `host_rd_lsr` and `rx_done` together. In the following cycle it expects bit 1 still set, the head's flags erased and bit 7 dropped, since no flagged entry remains. A full store that is pushed and popped in one cycle is provoked the same way and must show no overrun. Long pseudo-random runs in both modes compare every status bit against an arithmetic queue model.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      single,
    input  logic      push,
    input  logic      pop,
    input  logic      clr_head,
    input  rx_entry_t wr_ent,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      flags_left
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CW-1:0]  cnt, cnt_d, fcnt, fcnt_d, cap;
    occ_state_t     st_q, st_d;

    function automatic logic flagged(input rx_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign head       = mem[rp];
    assign cap        = single ? CW'(1) : CW'(DEPTH);
    assign flags_left = (fcnt_d != '0);

    always_comb begin
        cnt_d  = cnt + CW'(push) - CW'(pop);
        fcnt_d = fcnt + CW'(push && flagged(wr_ent))
                      - CW'((pop || clr_head) && flagged(head));
        if (cnt_d == '0)
            st_d = OCC_EMPTY;
        else if (cnt_d == cap)
            st_d = OCC_FULL;
        else
            st_d = OCC_PART;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= OCC_EMPTY;
        else
            st_q <= st_d;
    end

    // state outputs
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (st_q)
            OCC_EMPTY: empty = 1'b1;
            OCC_PART:  ;
            OCC_FULL:  full  = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            fcnt <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            cnt  <= cnt_d;
            fcnt <= fcnt_d;
            if (clr_head) begin
                mem[rp].brk  <= 1'b0;
                mem[rp].ferr <= 1'b0;
                mem[rp].perr <= 1'b0;
            end
            if (push) begin
                mem[wp] <= wr_ent;
                wp      <= nxt(wp);
            end
            if (pop)
                rp <= nxt(rp);
        end
    end

    // R3
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cap);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

endmodule

// File: rtl/tx_hold_track.sv
module tx_hold_track #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic single,
    input  logic load,
    input  logic move,
    input  logic shift_busy,
    output logic thr_empty,
    output logic tx_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt, cnt_mid, cap;
    logic          dec, inc;

    assign cap       = single ? CW'(1) : CW'(DEPTH);
    assign dec       = move && (cnt != '0);
    assign cnt_mid   = cnt - CW'(dec);
    assign inc       = load && (cnt_mid < cap);
    assign thr_empty = (cnt == '0);
    assign tx_empty  = thr_empty && !shift_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_mid + CW'(inc);
    end

    // R9
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !move) |=> !thr_empty);

endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
    import uart_lsr_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_mode,
    input  logic       rx_done,
    input  logic [7:0] rx_char,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       host_rd_data,
    input  logic       host_rd_lsr,
    input  logic       host_wr_lsr,
    input  logic       tx_load,
    input  logic       tx_move,
    input  logic       tx_shift_busy,
    input  logic       lsi_en,
    output logic [7:0] lsr,
    output logic [7:0] rx_head,
    output logic       lsi_irq
);
    rx_entry_t wr_ent, head;
    logic      single, empty, full, flags_left;
    logic      host_pop, force_pop, overrun, push, pop, clr_head;
    logic      oe_q, sum_q, thr_empty, tx_empty;

    assign single    = !fifo_mode;
    assign wr_ent    = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_char};
    assign host_pop  = host_rd_data && !empty;
    assign overrun   = rx_done && full && !host_pop;
    assign force_pop = overrun && single;
    assign push      = rx_done && (!full || host_pop || single);
    assign pop       = host_pop || force_pop;
    assign clr_head  = host_rd_lsr && !empty && !pop;

    rx_tag_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .single     (single),
        .push       (push),
        .pop        (pop),
        .clr_head   (clr_head),
        .wr_ent     (wr_ent),
        .head       (head),
        .empty      (empty),
        .full       (full),
        .flags_left (flags_left)
    );

    tx_hold_track #(.DEPTH(TX_DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .single     (single),
        .load       (tx_load),
        .move       (tx_move),
        .shift_busy (tx_shift_busy),
        .thr_empty  (thr_empty),
        .tx_empty   (tx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            sum_q <= 1'b0;
        end else begin
            oe_q  <= overrun || (oe_q && !host_rd_lsr);
            sum_q <= fifo_mode && (flags_left || (sum_q && !host_rd_lsr));
        end
    end

    always_comb begin
        lsr[0] = !empty;
        lsr[1] = oe_q;
        lsr[2] = !empty && head.perr;
        lsr[3] = !empty && head.ferr;
        lsr[4] = !empty && head.brk;
        lsr[5] = thr_empty;
        lsr[6] = tx_empty;
        lsr[7] = sum_q;
    end

    assign rx_head = empty ? 8'h00 : head.data;
    assign lsi_irq = lsi_en && (lsr[4:1] != 4'b0);

    // R2
    dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !full) |=> lsr[0]);

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && lsr[0] && full && !host_rd_data) |=> lsr[1]);

    // R7
    lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_lsr && !rx_done && !host_rd_data) |=> (lsr[4:1] == 4'b0));

    // R8
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[7] && !host_rd_lsr && fifo_mode) |=> (lsr[7] || !fifo_mode));

    // R10
    temt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_shift_busy |-> !lsr[6]);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsi_irq |-> lsi_en);

    // R12
    wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_lsr && !host_rd_lsr && !rx_done && !host_rd_data && !tx_load && !tx_move)
        |=> $stable(lsr[5:0]));

endmodule

// File: tb/uart_lsr_tracker_tb.sv
module uart_lsr_tracker_tb;
    localparam int RXD = 4;
    localparam int TXD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b1;
    logic       rx_done = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
    logic [7:0] rx_char = 8'h00;
    logic       host_rd_data = 0, host_rd_lsr = 0, host_wr_lsr = 0;
    logic       tx_load = 0, tx_move = 0, tx_shift_busy = 0, lsi_en = 0;
    logic [7:0] lsr, rx_head;
    logic       lsi_irq;

    int total = 0;
    int bad   = 0;

    logic [10:0] q[$];
    logic        m_oe = 0, m_sum = 0;
    int          m_tx = 0;

    always #5 clk = ~clk;

    uart_lsr_tracker #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .rx_done(rx_done), .rx_char(rx_char), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .host_rd_data(host_rd_data), .host_rd_lsr(host_rd_lsr),
        .host_wr_lsr(host_wr_lsr), .tx_load(tx_load), .tx_move(tx_move),
        .tx_shift_busy(tx_shift_busy), .lsi_en(lsi_en),
        .lsr(lsr), .rx_head(rx_head), .lsi_irq(lsi_irq)
    );

    // arithmetic queue model of the requirements
    always @(posedge clk) begin
        int cap, tcap, n, nf;
        logic hp, full, ovr, pop, push, dec;
        if (!rst_n) begin
            q.delete();
            m_oe = 0; m_sum = 0; m_tx = 0;
        end else begin
            cap  = fifo_mode ? RXD : 1;
            n    = q.size();
            hp   = host_rd_data && n > 0;
            full = (n == cap);
            ovr  = rx_done && full && !hp;
            pop  = hp || (ovr && !fifo_mode);
            push = rx_done && (!full || hp || !fifo_mode);
            if (host_rd_lsr && n > 0 && !pop) q[0][10:8] = 3'b000;
            if (pop) void'(q.pop_front());
            if (push) q.push_back({rx_brk, rx_ferr, rx_perr, rx_char});
            m_oe = ovr || (m_oe && !host_rd_lsr);
            nf = 0;
            foreach (q[i]) if (q[i][10:8] != 3'b000) nf++;
            m_sum = fifo_mode && (nf != 0 || (m_sum && !host_rd_lsr));
            tcap = fifo_mode ? TXD : 1;
            dec  = tx_move && m_tx > 0;
            m_tx = m_tx - int'(dec);
            if (tx_load && m_tx < tcap) m_tx++;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cmp();
        logic [7:0] e;
        logic [2:0] hf;
        hf = (q.size() > 0) ? q[0][10:8] : 3'b000;
        e  = {m_sum, (m_tx == 0) && !tx_shift_busy, m_tx == 0, hf, m_oe, q.size() > 0};
        chk("R2 data ready", 8'(lsr[0]), 8'(e[0]));
        chk("R4 overrun", 8'(lsr[1]), 8'(e[1]));
        chk("R6 head flags", 8'(lsr[4:2]), 8'(e[4:2]));
        chk("R9 holding empty", 8'(lsr[5]), 8'(e[5]));
        chk("R10 tx empty", 8'(lsr[6]), 8'(e[6]));
        chk("R8 summary", 8'(lsr[7]), 8'(e[7]));
        chk("R3 head data", rx_head, (q.size() > 0) ? q[0][7:0] : 8'h00);
        chk("R11 irq", 8'(lsi_irq), 8'(lsi_en && (e[4:1] != 4'b0)));
    endtask

    task automatic tick();
        @(negedge clk);
        cmp();
        rx_done = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        host_rd_data = 0; host_rd_lsr = 0; host_wr_lsr = 0;
        tx_load = 0; tx_move = 0;
    endtask

    task automatic rx(input logic [7:0] d, input logic [2:0] f);
        rx_done = 1; rx_char = d;
        rx_brk = f[2]; rx_ferr = f[1]; rx_perr = f[0];
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 0;
        fifo_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic sweep(input int cycles, inout logic [31:0] s);
        for (int c = 0; c < cycles; c++) begin
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
            rx_done       = s[0] & s[1];
            rx_char       = s[15:8];
            rx_perr       = s[2] & s[3];
            rx_ferr       = s[4] & s[5];
            rx_brk        = s[6] & s[7] & s[2];
            host_rd_data  = s[16] & s[17];
            host_rd_lsr   = s[18] & s[19] & s[20];
            host_wr_lsr   = s[21] & s[22];
            tx_load       = s[23] & s[24];
            tx_move       = s[25] & s[26];
            tx_shift_busy = s[27];
            if (s[28] & s[29] & s[30]) lsi_en = ~lsi_en;
            tick();
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [7:0]  snap;
        seed = 32'h1ACE_5EED;

        // FIFO mode, directed
        do_reset(1'b1);
        chk("R1 reset lsr", lsr, 8'h60);
        chk("R1 reset irq", 8'(lsi_irq), 8'h00);
        chk("R1 reset head", rx_head, 8'h00);
        lsi_en = 1;
        rx(8'h11, 3'b000); tick();
        rx(8'h22, 3'b000); tick();
        rx(8'h33, 3'b001); tick();
        rx(8'h44, 3'b000); tick();
        chk("R6 flags behind head hidden", 8'(lsr[4:2]), 8'h00);
        chk("R8 summary set", 8'(lsr[7]), 8'h01);
        rx(8'h55, 3'b000); tick();
        chk("R4 overrun set", 8'(lsr[1]), 8'h01);
        chk("R4 dropped char", rx_head, 8'h11);
        host_rd_lsr = 1; tick();
        chk("R7 overrun cleared", 8'(lsr[1]), 8'h00);
        host_rd_data = 1; rx(8'h66, 3'b000); tick();
        chk("R13 push with read no overrun", 8'(lsr[1]), 8'h00);
        chk("R13 head advanced", rx_head, 8'h22);
        host_rd_data = 1; tick();
        chk("R6 parity at head", 8'(lsr[2]), 8'h01);
        chk("R11 irq raised", 8'(lsi_irq), 8'h01);
        rx(8'h77, 3'b000); tick();
        host_rd_lsr = 1; rx(8'h88, 3'b000); tick();
        chk("R7 overrun wins over read", 8'(lsr[1]), 8'h01);
        chk("R7 head flags cleared", 8'(lsr[2]), 8'h00);
        chk("R8 summary cleared", 8'(lsr[7]), 8'h00);
        snap = lsr;
        host_wr_lsr = 1; tick();
        chk("R12 write ignored", lsr, snap);
        tx_load = 1; tick();
        tx_load = 1; tick();
        chk("R9 holding loaded", 8'(lsr[5]), 8'h00);
        tx_move = 1; tick();
        chk("R9 one byte left", 8'(lsr[5]), 8'h00);
        tx_move = 1; tx_shift_busy = 1; tick();
        chk("R9 holding empty", 8'(lsr[5]), 8'h01);
        chk("R10 shift busy", 8'(lsr[6]), 8'h00);
        tx_shift_busy = 0; tick();
        chk("R10 all empty", 8'(lsr[6]), 8'h01);
        sweep(6000, seed);

        // single-buffer mode
        do_reset(1'b0);
        rx(8'hA1, 3'b010); tick();
        rx(8'hB2, 3'b000); tick();
        chk("R5 replaced char", rx_head, 8'hB2);
        chk("R5 overrun set", 8'(lsr[1]), 8'h01);
        chk("R8 zero in single mode", 8'(lsr[7]), 8'h00);
        sweep(6000, seed);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule